// File: doc/BRIEF.md
# Latched Interrupt Status with Mask

The block collects single-cycle event pulses from the rest of a network controller into a 32-bit status word. It raises one interrupt request line when any pending status bit is also enabled in a 32-bit mask word. Four dedicated inputs report completed transmit descriptors that carry an interrupt request, one for each transmit priority queue. Each of these sets its own status bit.

Software reads the status word through a one-cycle read strobe, and that read clears the whole word. Software loads the mask through a write strobe. A status bit stays pending whether or not it is enabled, so masked events are still visible when the status word is read. An event that lands in the same cycle as a clearing read survives the clear and is returned by the next read.

Top module: `irq_status_ctrl`

## Requirements
- R1: A 1 on any bit of `evt_i` during a clock edge sets the matching status bit. The bit holds until a status read clears it, and several bits may be set in the same cycle.
- R2: Status bits latch whatever the mask holds. A masked event is still returned by a later status read.
- R3: `irq_o` is high exactly when some bit is 1 both in the status word and in the mask word. It follows the registered state with no added cycle.
- R4: A read with `rd_sel_i`=0 (status) returns, on `rd_data_o` in the cycle after the strobe, the status held before that edge. The same edge clears every status bit.
- R5: `txq_done_i[q]` sets status bit 24+q, for queues q = 0 to 3.
- R6: A write with `wr_sel_i`=0 (status) changes neither the status word nor the mask.
- R7: A write with `wr_sel_i`=1 loads `wr_data_i` into the mask. `irq_o` reflects the new mask from the next cycle, and the status word is left unchanged.
- R8: A status bit whose event arrives in the same cycle as a clearing read stays set after that read. The read itself still returns the prior value.
- R9: A read with `rd_sel_i`=1 returns the mask on `rd_data_o` one cycle later and does not clear status.
- R10: After reset the status word and the mask are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status bit |
| txq_done_i | input | 4 | Descriptor-with-interrupt completion, one per transmit queue |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read target: 0 status (clears), 1 mask |
| rd_data_o | output | 32 | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (ignored), 1 mask |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Interrupt request |

## Verification
A status bit stuck at 0, or one that drops out early, shows up on the next status read. It also shows at once on `irq_o` when that bit is enabled in the mask. A wrong clear is seen one read later: a second read returns stale bits, or a colliding event is missing. Mask corruption changes `irq_o` in the cycle after the mask write and can be read back on `rd_data_o` one cycle after a mask read. The bench sweeps every status bit through latch, masked hold, enabled request and clear, and sweeps every mask bit against matching and non-matching events.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W_DEF  = 32;
  localparam int TXQ_N_DEF   = 4;
  localparam int TXQ_LSB_DEF = 24;
  localparam logic SEL_STAT = 1'b0;
  localparam logic SEL_MASK = 1'b1;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
  parameter int DATA_W  = 32,
  parameter int TXQ_N   = 4,
  parameter int TXQ_LSB = 24
) (
  input  logic [DATA_W-1:0] evt_i,
  input  logic [TXQ_N-1:0]  txq_done_i,
  output logic [DATA_W-1:0] set_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= TXQ_LSB && b < TXQ_LSB + TXQ_N) begin : g_txq
      assign set_o[b] = evt_i[b] | txq_done_i[b-TXQ_LSB];
    end else begin : g_gen
      assign set_o[b] = evt_i[b];
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] stat_o
);
  // set wins over clear so a colliding event survives the read
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[b] <= 1'b0;
      else if (set_i[b]) stat_o[b] <= 1'b1;
      else if (clr_i)    stat_o[b] <= 1'b0;
    end
  end

  // R8
  set_survives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (stat_o & $past(set_i)) == $past(set_i));
  // R4
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && set_i == '0 |=> stat_o == '0);
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && set_i == '0 |=> $stable(stat_o));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (wr_en_i) mask_o <= wr_data_i;
  end

  // R6
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_req_tree.sv
module irq_req_tree #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] hit;
  assign hit   = stat_i & mask_i;
  assign irq_o = |hit;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int DATA_W  = irq_pkg::DATA_W_DEF,
  parameter int TXQ_N   = irq_pkg::TXQ_N_DEF,
  parameter int TXQ_LSB = irq_pkg::TXQ_LSB_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [TXQ_N-1:0]  txq_done_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] set_w, stat_q, mask_q;
  logic              stat_clr, mask_wr;

  assign stat_clr = rd_en_i && (rd_sel_i == irq_pkg::SEL_STAT);
  // status has no write path
  assign mask_wr  = wr_en_i && (wr_sel_i == irq_pkg::SEL_MASK);

  irq_src_merge #(.DATA_W(DATA_W), .TXQ_N(TXQ_N), .TXQ_LSB(TXQ_LSB)) u_merge (
    .evt_i      (evt_i),
    .txq_done_i (txq_done_i),
    .set_o      (set_w)
  );

  irq_status_bank #(.DATA_W(DATA_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mask_wr),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_q)
  );

  irq_req_tree #(.DATA_W(DATA_W)) u_req (
    .stat_i (stat_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= (rd_sel_i == irq_pkg::SEL_MASK) ? mask_q : stat_q;
  end

  // R4
  rd_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr |=> rd_data_o == $past(stat_q));
  // R9
  rd_mask_noclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_sel_i == irq_pkg::SEL_MASK && set_w == '0 |=> $stable(stat_q));
  // R6
  wr_stat_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == irq_pkg::SEL_STAT && !rd_en_i && set_w == '0
      |=> $stable(stat_q) && $stable(mask_q));
  // R3
  irq_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_q != '0 && mask_q != '0);
  // R2
  masked_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w != '0 |=> stat_q != '0);
endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt_i = '0;
  logic [3:0]  txq_done_i = '0;
  logic        rd_en_i = 1'b0, rd_sel_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  irq_status_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .txq_done_i(txq_done_i),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic [31:0] ev, input logic [3:0] tq);
    evt_i = ev; txq_done_i = tq;
    tick();
    evt_i = '0; txq_done_i = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] val);
    rd_en_i = 1'b1; rd_sel_i = sel;
    tick();
    rd_en_i = 1'b0;
    val = rd_data_o;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    tick();
    rd(1'b1, v); chk("R10 mask", v, 32'h0);
    rd(1'b0, v); chk("R10 status", v, 32'h0);

    // R1 R2: every bit latches while masked, then clears on read
    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i, 4'h0);
      tick();
      chk("R2 masked irq", {31'b0, irq_o}, 32'h0);
      rd(1'b0, v); chk("R1 latched bit", v, 32'h1 << i);
      rd(1'b0, v); chk("R4 cleared", v, 32'h0);
    end

    // R1 several bits at once
    pulse(32'hA5A5_0F0F, 4'h0);
    pulse(32'h0000_3000, 4'h0);
    rd(1'b0, v); chk("R1 multi", v, 32'hA5A5_3F0F);

    // R3 R7: each mask bit against a matching and a neighbouring event
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < 2; k++) begin
        int j = (i + k) % 32;
        wr(1'b1, 32'h1 << i);
        chk("R7 mask readback pre", {31'b0, irq_o}, 32'h0);
        pulse(32'h1 << j, 4'h0);
        chk("R3 irq", {31'b0, irq_o}, {31'b0, (i == j)});
        wr(1'b1, 32'h0);
        chk("R7 mask off irq", {31'b0, irq_o}, 32'h0);
        wr(1'b1, 32'h1 << i);
        chk("R7 mask on irq", {31'b0, irq_o}, {31'b0, (i == j)});
        rd(1'b0, v); chk("R7 status kept", v, 32'h1 << j);
        chk("R4 irq after clear", {31'b0, irq_o}, 32'h0);
      end
    end
    wr(1'b1, 32'h0);

    // R5 transmit queues
    for (int q = 0; q < 4; q++) begin
      pulse(32'h0, 4'h1 << q);
      rd(1'b0, v); chk("R5 txq bit", v, 32'h1 << (24 + q));
    end

    // R8 event colliding with clearing read
    pulse(32'h0000_00F0, 4'h0);
    evt_i = 32'h0101_0001; txq_done_i = 4'h2;
    rd(1'b0, v);
    evt_i = '0; txq_done_i = '0;
    chk("R8 prior value", v, 32'h0000_00F0);
    rd(1'b0, v); chk("R8 survivor", v, 32'h0301_0001);

    // R6 status writes ignored, R9 mask read does not clear
    wr(1'b1, 32'h0000_FF00);
    pulse(32'h0C00_0003, 4'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    wr(1'b0, 32'h0000_0000);
    rd(1'b1, v); chk("R6 mask intact", v, 32'h0000_FF00);
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
    rd(1'b1, v); chk("R9 mask read", v, 32'h0000_FF00);
    rd(1'b0, v); chk("R6 R9 status intact", v, 32'h0C00_0003);

    // R10 reset mid-run
    wr(1'b1, 32'hFFFF_FFFF);
    pulse(32'h8000_0000, 4'h0);
    chk("R3 irq set", {31'b0, irq_o}, 32'h1);
    rst_ni = 1'b0;
    tick();
    chk("R10 irq reset", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    tick();
    rd(1'b1, v); chk("R10 mask reset", v, 32'h0);
    rd(1'b0, v); chk("R10 status reset", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule